// File: doc/BRIEF.md
# CAN Receive Bit Sampler with Stuff-Bit Removal

This block watches an oversampled CAN receive line and turns it into a stream of frame bits with the stuff bits taken out. While the bus is idle it waits for the first dominant (logic 0) level. The clock cycle in which that level is first seen becomes the start-of-frame anchor. Every later bit is then sampled at a fixed point inside its bit period. Each sample instant is computed from that single anchor. The block never resynchronises to later edges.

Each sampled bit is checked against the run of equal bits before it. A bit of opposite value after five equal bits is a stuff bit. It is flagged on a strobe of its own and dropped from the stream. A downstream frame parser reads the destuffed bits together with their frame-bit index. The parser turns stuff detection off for the fixed-form tail of the frame and pulses an end-of-frame input to send the sampler back to idle.

Top module: `can_rx_sampler`

## Requirements
- R1: While idle, a recessive input (1) produces no output strobes and has no other effect. The first dominant sample (0) leaves idle, and its clock cycle becomes the start-of-frame (SOF) cycle.
- R2: The bit period in clocks is PERIOD = round(CLK_HZ / BIT_RATE). The sample offset is OFFSET = round(PERIOD × SAMPLE_PCT / 100). With the defaults (50 MHz, 1 Mbit/s, 70 %) these are 50 and 35, so raw bit 0 is reported 36 cycles after the SOF cycle.
- R3: Raw bit n is sampled from rx_i in cycle SOF + n×PERIOD + OFFSET. The timing depends only on the anchor, not on later edges. Its result appears on the outputs one clock later, and bit_o carries the sampled value.
- R4: A sampled bit is a stuff bit when it follows five equal raw bits and has the opposite value. A stuff bit pulses stuff_o for one cycle instead of bit_valid_o. The run then restarts counting at the stuff bit itself.
- R5: bit_idx_o is 0 for the first delivered bit and rises by one for each delivered bit. Stuff bits never advance it.
- R6: While stuff_en_i is low at a sample instant, that bit is always delivered on bit_valid_o, whatever the run before it.
- R7: frame_end_i high returns the block to idle and clears the run history and the index. It takes priority over a sample due in the same cycle, which is then not reported.
- R8: A run of more than five equal bits is not itself stuffing. The next bit of opposite value after such a run is treated as a stuff bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_i | input | 1 | CAN receive level, already synchronised (0 = dominant) |
| stuff_en_i | input | 1 | Enables stuff-bit detection at sample instants |
| frame_end_i | input | 1 | End-of-frame pulse from the parser; returns to idle |
| bit_valid_o | output | 1 | One-cycle strobe for a delivered frame bit |
| bit_o | output | 1 | Value of the delivered frame bit |
| bit_idx_o | output | IDX_W | Destuffed index of the delivered frame bit |
| stuff_o | output | 1 | One-cycle strobe for a removed stuff bit |

## Verification
The bench drives the line with transmitters that are too slow and too fast, so that edges drift against the anchor. A sampler that re-aligned to edges, or that stepped from the previous sample, would pick different raw bits than the reference model predicts. Stuff patterns are placed right after a removed stuff bit and after runs of six or more equal bits. A design that restarted its run at zero, or that cleared it after a violation, would flag the wrong bit. An end-of-frame pulse is placed exactly on a sample instant, and stuff detection is switched off over a long recessive tail. A design that reported that bit, or kept destuffing the tail, would show up as an extra or missing strobe or an index that is off by one.

// File: rtl/can_rx_sampler.sv
module can_rx_sampler #(
  parameter int CLK_HZ     = 50_000_000,
  parameter int BIT_RATE   = 1_000_000,
  parameter int SAMPLE_PCT = 70,
  parameter int MAX_BITS   = 256,
  parameter int IDX_W      = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_i,
  input  logic             stuff_en_i,
  input  logic             frame_end_i,
  output logic             bit_valid_o,
  output logic             bit_o,
  output logic [IDX_W-1:0] bit_idx_o,
  output logic             stuff_o
);
  localparam int PERIOD = (CLK_HZ + BIT_RATE / 2) / BIT_RATE;
  localparam int OFFSET = (PERIOD * SAMPLE_PCT + 50) / 100;
  localparam int TW     = $clog2(PERIOD * MAX_BITS + 1) + 1;

  logic             busy;
  logic [TW-1:0]    elapsed, target;
  logic [2:0]       run;
  logic             last;
  logic [IDX_W-1:0] idx;

  wire hit      = busy && (elapsed == target);
  wire is_stuff = stuff_en_i && (run == 3'd5) && (rx_i != last);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy        <= 1'b0;
      elapsed     <= '0;
      target      <= '0;
      run         <= '0;
      last        <= 1'b0;
      idx         <= '0;
      bit_valid_o <= 1'b0;
      bit_o       <= 1'b0;
      bit_idx_o   <= '0;
      stuff_o     <= 1'b0;
    end else begin
      bit_valid_o <= 1'b0;
      stuff_o     <= 1'b0;
      if (frame_end_i) begin
        busy    <= 1'b0;
        elapsed <= '0;
        target  <= '0;
        run     <= '0;
        last    <= 1'b0;
        idx     <= '0;
      end else if (!busy) begin
        if (!rx_i) begin
          busy    <= 1'b1;
          elapsed <= TW'(1);
          target  <= TW'(OFFSET);
          run     <= '0;
          idx     <= '0;
        end
      end else begin
        elapsed <= elapsed + TW'(1);
        if (hit) begin
          target <= target + TW'(PERIOD);
          last   <= rx_i;
          if (is_stuff) begin
            stuff_o <= 1'b1;
            run     <= 3'd1;
          end else begin
            bit_valid_o <= 1'b1;
            bit_o       <= rx_i;
            bit_idx_o   <= idx;
            idx         <= idx + IDX_W'(1);
            if (run != 3'd0 && rx_i == last)
              run <= (run == 3'd5) ? 3'd5 : run + 3'd1;
            else
              run <= 3'd1;
          end
        end
      end
    end
  end

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> !bit_valid_o && !stuff_o);

  assert_anchor_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !frame_end_i) |=> target == $past(target) + TW'(PERIOD));

  assert_stuff_after_five_R4: assert property (@(posedge clk) disable iff (!rst_n)
    stuff_o |-> $past(run) == 3'd5 && $past(stuff_en_i));

  assert_one_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(stuff_o && bit_valid_o));

  assert_idx_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    stuff_o |-> idx == $past(idx));

  assert_idx_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bit_valid_o |-> idx == $past(idx) + IDX_W'(1));

  assert_end_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end_i |=> !busy && idx == '0 && !bit_valid_o && !stuff_o);
endmodule

// File: tb/can_rx_sampler_tb.sv
`timescale 1ns/1ps
module can_rx_sampler_tb;
  localparam int CLK_HZ = 50_000_000;
  localparam int RATE   = 1_000_000;
  localparam int PCT    = 70;
  localparam int P      = (CLK_HZ + RATE / 2) / RATE;
  localparam int OFF    = (P * PCT + 50) / 100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx = 1'b1, sen = 1'b1, fend = 1'b0;
  logic vld, bitv, stf;
  logic [7:0] idxv;

  always #10 clk = ~clk;

  can_rx_sampler u_dut (
    .clk(clk), .rst_n(rst_n), .rx_i(rx), .stuff_en_i(sen), .frame_end_i(fend),
    .bit_valid_o(vld), .bit_o(bitv), .bit_idx_o(idxv), .stuff_o(stf)
  );

  int checks = 0, fails = 0;
  string phase = "R1";

  // reference model state
  bit m_idle = 1;
  int m_k = 0, m_n = 0, m_idx = 0;
  int q[$];
  bit e_vld = 0, e_bit = 0, e_stf = 0;
  int e_idx = 0;

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s (%s phase) actual=%0d expected=%0d at %0t", tag, phase, act, exp, $time);
    end
  endtask

  task automatic model_step(bit r, bit e, bit s);
    e_vld = 0; e_stf = 0;
    if (e) begin
      m_idle = 1; m_idx = 0; q.delete();
    end else if (m_idle) begin
      if (!r) begin m_idle = 0; m_k = 1; m_n = 0; m_idx = 0; q.delete(); end
    end else begin
      if (m_k == m_n * P + OFF) begin
        bit st = 0;
        m_n++;
        if (s && q.size() >= 5 && r != q[$]) begin
          st = 1;
          for (int i = 1; i <= 5; i++) if (q[q.size() - i] != q[$]) st = 0;
        end
        if (st) begin
          e_stf = 1; q.delete(); q.push_back(r);
        end else begin
          e_vld = 1; e_bit = r; e_idx = m_idx; m_idx++; q.push_back(r);
        end
      end
      m_k++;
    end
  endtask

  task automatic tick(bit r, bit e, bit s);
    rx = r; fend = e; sen = s;
    @(posedge clk);
    model_step(r, e, s);
    @(negedge clk);
    check("R3 valid", vld, e_vld);
    check("R4 stuff", stf, e_stf);
    if (e_vld) begin
      check("R3 bit", bitv, e_bit);
      check("R5 index", idxv, e_idx);
    end
  endtask

  task automatic drive_raw(string bits, int per, bit s);
    for (int i = 0; i < bits.len(); i++)
      repeat (per) tick(bits[i] == "1", 1'b0, s);
  endtask

  task automatic end_frame();
    tick(1'b1, 1'b1, 1'b1);
    repeat (20) tick(1'b1, 1'b0, 1'b1);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    check("R1 reset valid", vld, 0);
    check("R1 reset stuff", stf, 0);
    check("R1 reset index", idxv, 0);
    rst_n = 1'b1;

    phase = "R1";
    repeat (137) tick(1'b1, 1'b0, 1'b1);

    phase = "R2";
    begin
      int cnt = 0;
      rx = 1'b0; fend = 1'b0; sen = 1'b1;
      @(posedge clk); model_step(1'b0, 1'b0, 1'b1); @(negedge clk);
      while (!vld && cnt < 200) begin
        @(posedge clk); model_step(1'b0, 1'b0, 1'b1); @(negedge clk); cnt++;
      end
      check("R2 first sample latency", cnt + 1, OFF + 1);
      check("R3 SOF bit value", bitv, 0);
      check("R5 SOF index", idxv, 0);
    end
    end_frame();

    phase = "R4";
    drive_raw("0110010000011110111110110000010101", P, 1'b1);
    end_frame();

    phase = "R8";
    drive_raw("0000000010111111110100", P, 1'b1);
    end_frame();

    phase = "R6";
    drive_raw("01000001", P, 1'b1);
    drive_raw("1111111111100000001", P, 1'b0);
    drive_raw("00000101", P, 1'b1);
    end_frame();

    phase = "R3";
    drive_raw("0101100000111100101", P + 3, 1'b1);
    end_frame();
    drive_raw("0110000011110011010", P - 3, 1'b1);
    end_frame();

    phase = "R7";
    repeat (7) tick(1'b1, 1'b0, 1'b1);
    repeat (OFF) tick(1'b0, 1'b0, 1'b1);
    tick(1'b0, 1'b1, 1'b1);
    check("R7 no report on end cycle", vld, 0);
    repeat (P) tick(1'b1, 1'b0, 1'b1);
    drive_raw("0101", P, 1'b1);
    tick(1'b1, 1'b1, 1'b1);
    drive_raw("1110011", P, 1'b1);
    end_frame();

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(200000 * 20);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule